// File: doc/BRIEF.md
# Quadrature Output with Index Gating

This block converts step events from an interpolator into an incremental quadrature output with an index pulse. Each forward step moves an internal two-bit A/B state one place along a fixed four-state cycle, and each backward step moves it one place back. A cycle counter records how many complete A/B cycles have elapsed within one input signal period. It wraps at the interpolation factor minus one and is cleared by a zero-phase marker.

A raw zero-window signal from outside is qualified in two ways to form the index. A per-state enable mask selects the A/B states in which the index may pass. An optional cycle-count match is compared directly at low interpolation factors and scaled by eight at high ones. The qualified index can either follow the window directly or be held so that it changes only together with A/B transitions. The output stage can swap the A and B channels and invert any of the three channels. It drives registered positive and complementary pairs.

Top module: `quad_index_out`

## Requirements
- R1: A forward step (stepUp high, stepDown low) moves the state along (A,B) = (1,1) → (1,0) → (0,0) → (0,1) → (1,1). The outputs show the new state two clock edges after the strobe is sampled. When both strobes are high, or both are low, the state does not move.
- R2: A backward step (stepDown high, stepUp low) moves the state along the same order in reverse.
- R3: The cycle count rises by one on a forward step out of state (0,1) and wraps from ipf−1 to 0. It falls by one on a backward step out of state (1,1) and wraps from 0 to ipf−1.
- R4: zeroPhase clears the cycle count to 0 on the next edge and takes priority over any step. It leaves the A/B state unchanged.
- R5: cfgOut bit 4 = 0 maps P1 to A and P2 to B. Bit 4 = 1 maps P1 to B and P2 to A.
- R6: pa = P1 xor cfgOut[7], pb = P2 xor cfgOut[6], pz = P0 xor cfgOut[5].
- R7: na, nb and nz are always the inverse of pa, pb and pz. During reset the outputs are pa=1, na=0, pb=1, nb=0, pz=0, nz=1.
- R8: The index passes only in states whose enable bit is set. cfgOut[3] enables (1,1), cfgOut[2] enables (1,0), cfgOut[1] enables (0,0) and cfgOut[0] enables (0,1).
- R9: When cfgPos[7] = 0, the cycle count has no effect on the index.
- R10: When cfgPos[7] = 1 and ipf < 200, the index is blocked whenever the cycle count differs from cfgPos[6:0].
- R11: When cfgPos[7] = 1 and ipf ≥ 200, the index is blocked whenever the cycle count differs from 8 × cfgPos[6:0].
- R12: When cfgPos[7] = 1 and the match value (scaled or not) exceeds ipf−1, the index is never asserted.
- R13: With syncIndex = 1, P0 is updated only on the edge where the A/B outputs change, so a change of the zero window alone leaves pz unchanged.
- R14: With syncIndex = 0, P0 follows the gated window and is updated on every edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stepUp | input | 1 | Forward step strobe, one per clock |
| stepDown | input | 1 | Backward step strobe, one per clock |
| zeroPhase | input | 1 | Input phase is zero degrees; clears cycle count |
| zeroWindow | input | 1 | Raw zero-window signal |
| ipf | input | POS_W | Interpolation factor (cycles per input period) |
| cfgOut | input | 8 | Inversions [7:5], swap [4], state enables [3:0] |
| cfgPos | input | 8 | Count mask enable [7], match value [6:0] |
| syncIndex | input | 1 | 1: index changes only with A/B transitions |
| pa | output | 1 | Channel A positive |
| na | output | 1 | Channel A complement |
| pb | output | 1 | Channel B positive |
| nb | output | 1 | Channel B complement |
| pz | output | 1 | Index positive |
| nz | output | 1 | Index complement |

## Verification
The scaled match at high interpolation factors is the hardest case to reach. It only takes effect when the cycle count reaches eight times the match value, hundreds of steps into a period. The bench therefore walks whole periods at ipf values of 199 and 200, checking every step with both scaled and unscaled match values. Synchronized mode needs the window to change while the A/B state stands still. The bench toggles the window between steps and confirms that pz holds until the next step arrives.

// File: rtl/qio_pkg.sv
package qio_pkg;
  // Step command from control to datapath
  typedef struct packed {
    logic advance;
    logic retreat;
    logic clearPos;
  } stepCmd_t;

  // State index 0..3 stands for (A,B) = 11, 10, 00, 01
  function automatic logic [1:0] stateToAB(input logic [1:0] st);
    return {(st == 2'd0) || (st == 2'd1), (st == 2'd0) || (st == 2'd3)};
  endfunction
endpackage

// File: rtl/qio_ctrl.sv
module qio_ctrl
  import qio_pkg::*;
(
  input  logic     stepUp,
  input  logic     stepDown,
  input  logic     zeroPhase,
  output stepCmd_t cmd
);
  always_comb begin
    cmd.advance  = stepUp && !stepDown;
    cmd.retreat  = stepDown && !stepUp;
    cmd.clearPos = zeroPhase;
  end
endmodule

// File: rtl/qio_dp.sv
module qio_dp
  import qio_pkg::*;
#(
  parameter int POS_W    = 10,
  parameter int SCALE_AT = 200
) (
  input  logic             clk,
  input  logic             rstN,
  input  stepCmd_t         cmd,
  input  logic             zeroWindow,
  input  logic [POS_W-1:0] ipf,
  input  logic [7:0]       cfgOut,
  input  logic [7:0]       cfgPos,
  input  logic             syncIndex,
  output logic [1:0]       abState,
  output logic [POS_W-1:0] cyclePos,
  output logic [5:0]       outBus
);
  localparam int MW = POS_W + 4;

  logic [1:0]       shownState;
  logic             zHeld;
  logic [MW-1:0]    matchVal;
  logic [MW-1:0]    ipfWide;
  logic             posOk;
  logic             gated;
  logic             zNext;
  logic [1:0]       ab;
  logic             p1;
  logic             p2;
  logic [POS_W-1:0] posMax;

  assign posMax = ipf - POS_W'(1);

  // A/B cycle state and cycle count
  always_ff @(posedge clk) begin
    if (!rstN) begin
      abState  <= 2'd0;
      cyclePos <= '0;
    end else begin
      if (cmd.advance) begin
        abState <= abState + 2'd1;
        if (abState == 2'd3)
          cyclePos <= (cyclePos >= posMax) ? '0 : cyclePos + POS_W'(1);
      end else if (cmd.retreat) begin
        abState <= abState - 2'd1;
        if (abState == 2'd0)
          cyclePos <= (cyclePos == '0) ? posMax : cyclePos - POS_W'(1);
      end
      if (cmd.clearPos)
        cyclePos <= '0;
    end
  end

  // Index qualification
  always_comb begin
    ipfWide  = MW'(ipf);
    matchVal = (ipf >= POS_W'(SCALE_AT)) ? (MW'(cfgPos[6:0]) << 3) : MW'(cfgPos[6:0]);
    posOk    = !cfgPos[7] || ((matchVal < ipfWide) && (matchVal == MW'(cyclePos)));
    gated    = zeroWindow && cfgOut[3 - abState] && posOk;
    zNext    = (!syncIndex || (abState != shownState)) ? gated : zHeld;
    ab       = stateToAB(abState);
    p1       = cfgOut[4] ? ab[0] : ab[1];
    p2       = cfgOut[4] ? ab[1] : ab[0];
  end

  // Registered output pairs: {pa, na, pb, nb, pz, nz}
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shownState <= 2'd0;
      zHeld      <= 1'b0;
      outBus     <= 6'b100101;
    end else begin
      shownState <= abState;
      zHeld      <= zNext;
      outBus     <= {p1 ^ cfgOut[7], ~(p1 ^ cfgOut[7]),
                     p2 ^ cfgOut[6], ~(p2 ^ cfgOut[6]),
                     zNext ^ cfgOut[5], ~(zNext ^ cfgOut[5])};
    end
  end
endmodule

// File: rtl/quad_index_out.sv
module quad_index_out
  import qio_pkg::*;
#(
  parameter int POS_W    = 10,
  parameter int SCALE_AT = 200
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stepUp,
  input  logic             stepDown,
  input  logic             zeroPhase,
  input  logic             zeroWindow,
  input  logic [POS_W-1:0] ipf,
  input  logic [7:0]       cfgOut,
  input  logic [7:0]       cfgPos,
  input  logic             syncIndex,
  output logic             pa,
  output logic             na,
  output logic             pb,
  output logic             nb,
  output logic             pz,
  output logic             nz
);
  stepCmd_t         cmd;
  logic [1:0]       abState;
  logic [POS_W-1:0] cyclePos;
  logic [5:0]       outBus;

  qio_ctrl u_ctrl (
    .stepUp(stepUp), .stepDown(stepDown), .zeroPhase(zeroPhase), .cmd(cmd)
  );

  qio_dp #(.POS_W(POS_W), .SCALE_AT(SCALE_AT)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .zeroWindow(zeroWindow), .ipf(ipf),
    .cfgOut(cfgOut), .cfgPos(cfgPos), .syncIndex(syncIndex),
    .abState(abState), .cyclePos(cyclePos), .outBus(outBus)
  );

  assign {pa, na, pb, nb, pz, nz} = outBus;
endmodule

// File: rtl/qio_checker.sv
module qio_checker #(
  parameter int POS_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             stepUp,
  input logic             stepDown,
  input logic             zeroPhase,
  input logic             syncIndex,
  input logic [7:0]       cfgOut,
  input logic [1:0]       abState,
  input logic [POS_W-1:0] cyclePos,
  input logic             pa,
  input logic             na,
  input logic             pb,
  input logic             nb,
  input logic             pz,
  input logic             nz
);
  logic [1:0] armCnt;
  always_ff @(posedge clk) begin
    if (!rstN) armCnt <= 2'd0;
    else if (armCnt != 2'd3) armCnt <= armCnt + 2'd1;
  end

  assert_complement_R7: assert property (@(posedge clk) disable iff (!rstN)
    (na == !pa) && (nb == !pb) && (nz == !pz));

  assert_forward_R1: assert property (@(posedge clk) disable iff (!rstN)
    (stepUp && !stepDown) |=> (abState == $past(abState) + 2'd1));

  assert_backward_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stepDown && !stepUp) |=> (abState == $past(abState) - 2'd1));

  assert_zero_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    zeroPhase |=> (cyclePos == '0));

  assert_sync_hold_R13: assert property (@(posedge clk) disable iff (!rstN)
    ((armCnt == 2'd3) && syncIndex && $stable(syncIndex) && $stable(cfgOut)
     && $stable(pa) && $stable(pb)) |-> $stable(pz));
endmodule

bind quad_index_out qio_checker #(.POS_W(POS_W)) u_chk (
  .clk(clk), .rstN(rstN), .stepUp(stepUp), .stepDown(stepDown),
  .zeroPhase(zeroPhase), .syncIndex(syncIndex), .cfgOut(cfgOut),
  .abState(abState), .cyclePos(cyclePos),
  .pa(pa), .na(na), .pb(pb), .nb(nb), .pz(pz), .nz(nz)
);

// File: tb/quad_index_out_test.sv
`timescale 1ns/1ps
module quad_index_out_test;
  localparam int POS_W = 10;

  logic clk = 1'b0;
  logic rstN, stepUp, stepDown, zeroPhase, zeroWindow, syncIndex;
  logic [POS_W-1:0] ipf;
  logic [7:0] cfgOut, cfgPos;
  logic pa, na, pb, nb, pz, nz;

  int checks = 0;
  int failures = 0;
  int mState, mPos;
  bit mZ;

  always #4 clk = ~clk;

  quad_index_out #(.POS_W(POS_W)) uut (
    .clk(clk), .rstN(rstN), .stepUp(stepUp), .stepDown(stepDown),
    .zeroPhase(zeroPhase), .zeroWindow(zeroWindow), .ipf(ipf),
    .cfgOut(cfgOut), .cfgPos(cfgPos), .syncIndex(syncIndex),
    .pa(pa), .na(na), .pb(pb), .nb(nb), .pz(pz), .nz(nz)
  );

  function automatic bit gatedM();
    int m;
    bit ok;
    m  = (int'(ipf) >= 200) ? 8 * int'(cfgPos[6:0]) : int'(cfgPos[6:0]);
    ok = !cfgPos[7] || ((m < int'(ipf)) && (m == mPos));
    return zeroWindow && cfgOut[3 - mState] && ok;
  endfunction

  task automatic checkOut(string req);
    bit a, b, p1, p2, z;
    logic [5:0] exp, act;
    a  = (mState == 0) || (mState == 1);
    b  = (mState == 0) || (mState == 3);
    p1 = cfgOut[4] ? b : a;
    p2 = cfgOut[4] ? a : b;
    z  = syncIndex ? mZ : gatedM();
    exp = {p1 ^ cfgOut[7], !(p1 ^ cfgOut[7]), p2 ^ cfgOut[6], !(p2 ^ cfgOut[6]),
           z ^ cfgOut[5], !(z ^ cfgOut[5])};
    act = {pa, na, pb, nb, pz, nz};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s state=%0d pos=%0d actual=%b expected=%b", req, mState, mPos, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; stepUp = 0; stepDown = 0; zeroPhase = 0;
    repeat (3) @(negedge clk);
    checks++;
    if ({pa, na, pb, nb, pz, nz} !== 6'b100101) begin
      failures++;
      $display("FAIL R7 reset actual=%b expected=100101", {pa, na, pb, nb, pz, nz});
    end
    rstN = 1'b1;
    mState = 0; mPos = 0; mZ = 0;
    @(negedge clk);
  endtask

  task automatic step(bit up);
    stepUp = up; stepDown = !up;
    @(negedge clk);
    stepUp = 0; stepDown = 0;
    if (up) begin
      if (mState == 3) mPos = (mPos >= int'(ipf) - 1) ? 0 : mPos + 1;
      mState = (mState + 1) % 4;
    end else begin
      if (mState == 0) mPos = (mPos == 0) ? int'(ipf) - 1 : mPos - 1;
      mState = (mState + 3) % 4;
    end
    if (syncIndex) mZ = gatedM();
    @(negedge clk);
  endtask

  task automatic walk(bit up, int n, string req, bit toggleWin);
    for (int i = 0; i < n; i++) begin
      if (toggleWin) zeroWindow = ((i % 3) != 1);
      step(up);
      checkOut(req);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    zeroWindow = 1; syncIndex = 0; ipf = 10'd5; cfgOut = 8'h0F; cfgPos = 8'h00;
    rstN = 0; stepUp = 0; stepDown = 0; zeroPhase = 0;

    // Output mapping, inversion, state mask sweep (R1 R2 R5 R6 R8)
    for (int k = 0; k < 16; k++) begin
      cfgOut = {4'(k), 4'(k * 5 + 3)};
      cfgPos = 8'h00;
      doReset();
      walk(1'b1, 24, "R1 R5 R6 R8", 1'b1);
      walk(1'b0, 12, "R2 R5 R6 R8", 1'b1);
    end

    // Count-based blanking, unscaled (R3 R10) and disabled (R9)
    cfgOut = 8'h0F; zeroWindow = 1; ipf = 10'd5;
    cfgPos = 8'h83; doReset();
    walk(1'b1, 44, "R3 R10", 1'b0);
    walk(1'b0, 44, "R3 R10", 1'b0);
    cfgPos = 8'h03; doReset();
    walk(1'b1, 24, "R9", 1'b0);

    // Unscaled at ipf=199, scaled at ipf=200 (R10 R11)
    ipf = 10'd199; cfgPos = 8'h80 | 8'd20; cfgOut = 8'h2F; doReset();
    walk(1'b1, 800, "R10 high range", 1'b0);
    ipf = 10'd200; cfgPos = 8'h80 | 8'd2; doReset();
    walk(1'b1, 810, "R11", 1'b0);
    walk(1'b0, 20, "R11", 1'b0);

    // Match beyond ipf-1 never asserts (R12)
    ipf = 10'd5; cfgPos = 8'h87; cfgOut = 8'h0F; doReset();
    walk(1'b1, 44, "R12", 1'b0);
    ipf = 10'd200; cfgPos = 8'h80 | 8'd25; doReset();
    walk(1'b1, 820, "R12 scaled", 1'b0);

    // Zero phase clears count (R4)
    ipf = 10'd5; cfgPos = 8'h80; cfgOut = 8'h0F; doReset();
    walk(1'b1, 9, "R4 pre", 1'b0);
    zeroPhase = 1; stepUp = 1;
    @(negedge clk);
    zeroPhase = 0; stepUp = 0;
    mState = (mState + 1) % 4; mPos = 0;
    @(negedge clk);
    checkOut("R4");
    walk(1'b1, 16, "R4 after", 1'b0);

    // Direct index timing (R14)
    cfgPos = 8'h00; cfgOut = 8'h04; syncIndex = 0; doReset();
    step(1'b1);
    for (int i = 0; i < 4; i++) begin
      zeroWindow = i[0];
      @(negedge clk); @(negedge clk);
      checkOut("R14");
    end

    // Synchronized index timing (R13)
    syncIndex = 1; zeroWindow = 0; doReset();
    step(1'b1);
    checkOut("R13 entry");
    for (int i = 0; i < 4; i++) begin
      zeroWindow = !i[0];
      @(negedge clk); @(negedge clk);
      checkOut("R13 hold");
    end
    zeroWindow = 1;
    walk(1'b1, 8, "R13 step", 1'b0);
    zeroWindow = 0;
    @(negedge clk); @(negedge clk);
    checkOut("R13 hold after");
    walk(1'b0, 8, "R13 back", 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule